// File: doc/BRIEF.md
# Buffered-Duty PWM Time Base

This block produces a single pulse-width-modulated output from a 10-bit up-counter. The counter advances once for each pulse of a prescaled clock enable, chosen from eight incoming enables by a 3-bit select field. A period register sets the count at which the counter wraps to zero. A duty value sets how many counts of each period the output stays high.

Software never writes the duty value directly. It writes a staging register, and the staged value is copied into the live duty register only when the counter wraps, or at any time while counting is halted. A pulse width changed in the middle of a period therefore takes effect cleanly at the next period boundary.

Counting halts when the run bit is clear or when the low-power input is high. While halted, the counter sits at zero and reads back as 0xFC00. The low-power input also puts the period register back to its reset value. The period register can only be changed while counting is halted. An illegal write to it is dropped and leaves a sticky error flag set.

Top module: `bpwm_top`

## Requirements
- R1: While running, the 10-bit count rises by exactly one on each cycle in which the selected enable is high and holds otherwise; address 0 reads it as {6'b111111, count}.
- R2: Select code k (0 to 7, control bits 3:1) picks tick_i[k] as the counting enable; the bench drives tick_i[k] as a pulse every 2^k cycles.
- R3: Reset, a clear run bit (control bit 0) or a high lp_i forces the count to zero, so address 0 reads 0xFC00.
- R4: The period register (address 1) resets to 0xFFFF, reads its upper 6 bits as ones, and returns to 0xFFFF during any cycle in which lp_i is high.
- R5: When the count equals the lower 10 bits of the period register, the next selected enable clears it to zero, so one period lasts period+1 counts.
- R6: On that clearing enable the staging value is copied into the duty register; while counting is halted, the duty register follows the staging value every cycle.
- R7: A period write is ignored when the run bit is set, when lp_i is high, or when its lower 10 bits are zero; each such attempt sets the sticky error flag (control bit 4), which stays set until a control write with bit 4 at one clears it.
- R8: The staging register (address 2, lower 10 bits, upper bits read as zero) accepts writes at any time; a new value does not change the output before the next wrap.
- R9: pwm_o is registered: one cycle after a clock in which the counter is running and count < duty, it is high, and otherwise low. Duty 0 gives a steady low, a duty above the period gives a steady high, and the output is low while halted.
- R10: Address 3 reads {11'b0, error, select[2:0], run}. Read data is registered and shows the register named by bus_addr_i in the cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_i | input | 1 | Low-power / stop request; halts and reinitialises |
| tick_i | input | 8 | Prescaled clock enables, bit k pulses every 2^k cycles |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 count, 1 period, 2 staging, 3 control) |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Registered read data |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The hardest case to reach from the ports is a staging write that lands partway through a period. It has to be seen to leave the current pulse alone and change only the next one. The stimulus starts the counter with a short period, rewrites the staging register a few cycles later, and compares every output cycle against a reference queue. The illegal period writes are made both while running and while halted with a zero value, and the flag is then read back. Low-power entry is driven while a nonzero count is in progress, so that the forced clear and the period reinitialisation can both be observed.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  typedef enum logic [1:0] {
    A_CNT = 2'd0,
    A_CYC = 2'd1,
    A_BUF = 2'd2,
    A_CTL = 2'd3
  } bpwm_addr_e;
endpackage

// File: rtl/bpwm_tick_sel.sv
module bpwm_tick_sel #(
  parameter int N_TICK = 8,
  parameter int SEL_W  = $clog2(N_TICK)
) (
  input  logic [N_TICK-1:0] tick_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              tick_o
);
  always_comb tick_o = tick_i[sel_i];
endmodule

// File: rtl/bpwm_counter.sv
module bpwm_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cyc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end  = (cnt_q == cyc_i);
  assign match_o = run_i && tick_i && at_end;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (tick_i)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  // R3: halted counter sits at zero
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> cnt_q == '0);
  // R5: wrap after the period value
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && at_end) |=> cnt_q == '0);
  // R1: single step per enable
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && !at_end) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (run_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bpwm_regs.sv
module bpwm_regs
  import bpwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int REG_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lp_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] buf_o,
  output logic             start_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam int PAD   = REG_W - CNT_W;
  localparam int ERR_B = SEL_W + 1;

  logic [CNT_W-1:0] cyc_q, buf_q;
  logic             start_q, err_q;
  logic [SEL_W-1:0] sel_q;
  logic             wr_cyc, wr_buf, wr_ctl, cyc_bad;

  assign wr_cyc  = we_i && (addr_i == A_CYC);
  assign wr_buf  = we_i && (addr_i == A_BUF);
  assign wr_ctl  = we_i && (addr_i == A_CTL);
  assign cyc_bad = start_q || lp_i || (wdata_i[CNT_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q   <= '1;
      buf_q   <= '0;
      start_q <= 1'b0;
      sel_q   <= '0;
      err_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (wr_cyc) begin
        if (cyc_bad) err_q <= 1'b1;
        else         cyc_q <= wdata_i[CNT_W-1:0];
      end
      if (lp_i) cyc_q <= '1;
      if (wr_buf) buf_q <= wdata_i[CNT_W-1:0];
      if (wr_ctl) begin
        start_q <= wdata_i[0];
        sel_q   <= wdata_i[SEL_W:1];
        if (wdata_i[ERR_B]) err_q <= 1'b0;
      end
      case (addr_i)
        A_CNT:   rdata_o <= {{PAD{1'b1}}, cnt_i};
        A_CYC:   rdata_o <= {{PAD{1'b1}}, cyc_q};
        A_BUF:   rdata_o <= {{PAD{1'b0}}, buf_q};
        default: rdata_o <= {{(REG_W-SEL_W-2){1'b0}}, err_q, sel_q, start_q};
      endcase
    end
  end

  assign cyc_o   = cyc_q;
  assign buf_o   = buf_q;
  assign start_o = start_q;
  assign sel_o   = sel_q;

  // R7: period locked while running
  p_cyc_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (start_q && !lp_i) |=> $stable(cyc_q));
  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_ctl && wdata_i[ERR_B])) |=> err_q);
  // R4: low power restores the period
  p_lp_cyc_r4: assert property (@(posedge clk) disable iff (rst)
    lp_i |=> cyc_q == '1);
endmodule

// File: rtl/bpwm_out.sv
module bpwm_out #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             match_i,
  input  logic [CNT_W-1:0] buf_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      if (!run_i || match_i) duty_q <= buf_i;
      pwm_o <= run_i && (cnt_i < duty_q);
    end
  end

  // R6: staged value taken at the wrap
  p_duty_load_r6: assert property (@(posedge clk) disable iff (rst)
    match_i |=> duty_q == $past(buf_i));
  // R8: no duty change inside a running period
  p_duty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run_i && !match_i) |=> $stable(duty_q));
  // R9: output low while halted
  p_pwm_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !pwm_o);
endmodule

// File: rtl/bpwm_top.sv
module bpwm_top #(
  parameter int CNT_W  = 10,
  parameter int REG_W  = 16,
  parameter int N_TICK = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_i,
  input  logic [N_TICK-1:0] tick_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              pwm_o
);
  localparam int SEL_W = $clog2(N_TICK);

  logic [CNT_W-1:0] cnt, cyc, bufv;
  logic [SEL_W-1:0] sel;
  logic             start, run, tick, match;

  assign run = start && !lp_i;

  bpwm_regs #(.CNT_W(CNT_W), .REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .lp_i(lp_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .cnt_i(cnt), .rdata_o(bus_rdata_o), .cyc_o(cyc),
    .buf_o(bufv), .start_o(start), .sel_o(sel)
  );

  bpwm_tick_sel #(.N_TICK(N_TICK), .SEL_W(SEL_W)) u_sel (
    .tick_i(tick_i), .sel_i(sel), .tick_o(tick)
  );

  bpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(run), .tick_i(tick), .cyc_i(cyc),
    .cnt_o(cnt), .match_o(match)
  );

  bpwm_out #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .run_i(run), .match_i(match), .buf_i(bufv),
    .cnt_i(cnt), .pwm_o(pwm_o)
  );
endmodule

// File: tb/bpwm_top_tb_top.sv
`timescale 1ns/1ps
module bpwm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lp = 1'b0;
  logic [7:0]  tick = 8'h01;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        pwm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bpwm_top dut_i (
    .clk(clk), .rst(rst), .lp_i(lp), .tick_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  // enable pulses: bit k every 2^k cycles
  int tc = 0;
  always @(negedge clk) begin
    tc = tc + 1;
    for (int k = 0; k < 8; k++) tick[k] = ((tc % (1 << k)) == 0);
  end

  // reference model built from the requirements
  logic [9:0]  m_cnt, m_duty, m_cyc, m_buf;
  logic [2:0]  m_cks;
  logic        m_start, m_err;
  logic [15:0] m_rd;
  bit          pwm_q[$];

  always @(posedge clk) begin
    logic run, tk, mt, n_pwm, n_start, n_err;
    logic [9:0] n_cnt, n_duty, n_cyc, n_buf;
    logic [2:0] n_cks;
    if (rst) begin
      m_cnt = 0; m_duty = 0; m_cyc = 10'h3FF; m_buf = 0;
      m_cks = 0; m_start = 0; m_err = 0; m_rd = 0;
    end else begin
      run   = m_start && !lp;
      tk    = tick[m_cks];
      mt    = run && tk && (m_cnt == m_cyc);
      n_pwm = run && (m_cnt < m_duty);
      case (addr)
        2'd0: m_rd = {6'h3F, m_cnt};
        2'd1: m_rd = {6'h3F, m_cyc};
        2'd2: m_rd = {6'h00, m_buf};
        default: m_rd = {11'b0, m_err, m_cks, m_start};
      endcase
      n_cnt  = !run ? 10'd0 : (tk ? (mt ? 10'd0 : m_cnt + 10'd1) : m_cnt);
      n_duty = (!run || mt) ? m_buf : m_duty;
      n_cyc = m_cyc; n_buf = m_buf; n_cks = m_cks; n_start = m_start; n_err = m_err;
      if (we && addr == 2'd1) begin
        if (m_start || lp || wdata[9:0] == 10'd0) n_err = 1'b1;
        else n_cyc = wdata[9:0];
      end
      if (lp) n_cyc = 10'h3FF;
      if (we && addr == 2'd2) n_buf = wdata[9:0];
      if (we && addr == 2'd3) begin
        n_start = wdata[0]; n_cks = wdata[3:1];
        if (wdata[4]) n_err = 1'b0;
      end
      m_cnt = n_cnt; m_duty = n_duty; m_cyc = n_cyc; m_buf = n_buf;
      m_cks = n_cks; m_start = n_start; m_err = n_err;
      pwm_q.push_back(n_pwm);
    end
  end

  // monitor: every output cycle compared (R9, R5, R6, R8, R2)
  always @(negedge clk) begin
    if (pwm_q.size() > 0 && !done) begin
      bit e;
      e = pwm_q.pop_front();
      n_chk++;
      if (pwm !== e) begin
        n_bad++;
        $display("FAIL R9 pwm_o at %0t: got %b expected %b", $time, pwm, e);
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // read with a fixed expected value
  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a;
    @(negedge clk); chk(rdata, exp, tag);
  endtask

  // read checked against the reference model
  task automatic rdm(input logic [1:0] a, input string tag);
    @(negedge clk); addr = a;
    @(negedge clk); chk(rdata, m_rd, tag);
  endtask

  task automatic hold_pwm(input int n, input logic v, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); chk({15'b0, pwm}, {15'b0, v}, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({15'b0, pwm}, 16'h0, "R9 reset output");
    rd(2'd0, 16'hFC00, "R3 count after reset");
    rd(2'd1, 16'hFFFF, "R4 period after reset");
    rd(2'd3, 16'h0000, "R10 control after reset");
    // short period, select code 0
    wr(2'd1, 16'h0009);
    wr(2'd2, 16'h0004);
    rd(2'd2, 16'h0004, "R8 staging readback");
    wr(2'd3, 16'h0001);
    repeat (13) @(negedge clk);
    rdm(2'd0, "R1 count while running");
    rdm(2'd0, "R1 count steps");
    // illegal period write while running
    wr(2'd1, 16'h0003);
    rd(2'd1, 16'hFC09, "R7 period locked while running");
    rd(2'd3, 16'h0011, "R7 error flag set");
    // mid-period staging change
    repeat (3) @(negedge clk);
    wr(2'd2, 16'h0007);
    repeat (40) @(negedge clk);
    wr(2'd3, 16'h0011);
    rd(2'd3, 16'h0001, "R7 error cleared");
    // select code 3: enable every 8 cycles
    wr(2'd3, 16'h0007);
    rd(2'd3, 16'h0007, "R10 control readback");
    repeat (100) @(negedge clk);
    rdm(2'd0, "R2 count under slow enable");
    repeat (100) @(negedge clk);
    // duty above period: steady high
    wr(2'd2, 16'h000F);
    repeat (200) @(negedge clk);
    hold_pwm(30, 1'b1, "R9 duty above period");
    // duty zero: steady low
    wr(2'd2, 16'h0000);
    repeat (200) @(negedge clk);
    hold_pwm(30, 1'b0, "R9 duty zero");
    wr(2'd2, 16'h0005);
    wr(2'd3, 16'h0001);
    repeat (25) @(negedge clk);
    // low power while counting
    @(negedge clk); lp = 1'b1;
    rd(2'd0, 16'hFC00, "R3 count in low power");
    rd(2'd1, 16'hFFFF, "R4 period in low power");
    chk({15'b0, pwm}, 16'h0, "R9 output in low power");
    @(negedge clk); lp = 1'b0;
    // halted: zero period write rejected
    wr(2'd3, 16'h0000);
    rd(2'd0, 16'hFC00, "R3 count when halted");
    wr(2'd1, 16'h0000);
    rd(2'd1, 16'hFFFF, "R7 zero period rejected");
    rd(2'd3, 16'h0010, "R7 error after zero write");
    wr(2'd1, 16'h0006);
    rd(2'd1, 16'hFC06, "R4 period write when halted");
    wr(2'd3, 16'h0011);
    repeat (30) @(negedge clk);
    rdm(2'd0, "R5 count wraps at period");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule